// File: doc/BRIEF.md
# Two-Bit Adaptive Delta Modulation Encoder

This block turns a stream of signed fixed-point samples into a stream of 2-bit codewords. Each codeword carries the direction of the prediction error and one bit that records whether the step grew or shrank. The encoder holds a running prediction of the input and an adaptive step size. For every accepted sample it compares the input with the prediction and moves the prediction up or down by the newly adapted step.

The step adapts by a product of up to three factors. The first is a memory factor taken from whether the sign bit repeated. The second is a look-ahead factor, which compares the error magnitude with a midpoint threshold and picks a step-up or step-down ratio. The third is an extra boost applied when the step-down choice happens on two samples in a row. Together these give six possible step ratios. All constants are Q-format parameters.

A decoder that runs the same adaptation rule on the codewords rebuilds the `recon` output. The block also presents `recon` directly, so the reconstruction can be watched as it runs.

Top module: `adm2_encoder`

## Requirements
- R1: While `rst` is high on a clock edge, the prediction resets to 0, the step resets to `STEP_INIT`, both history bits reset to +1, `code` resets to 2'b11 and `codeValid` resets to 0.
- R2: The error is `sample` minus the prediction. `code[1]` is 1 when the error is zero or positive, and 0 when it is negative.
- R3: The memory factor is `ALPHA_Q` when the new sign bit equals the previous one, and `INV_ALPHA_Q` otherwise. The intermediate step is the old step scaled by this factor.
- R4: `code[0]` is 1 when the error magnitude is at least the intermediate step scaled by `MID_Q`. In that case the step-up factor `BETA_Q` is applied. Otherwise `code[0]` is 0 and `INV_BETA_Q` is applied.
- R5: When `code[0]` is 0 for both the current sample and the previous one, the step is further scaled by `GAMMA_Q`.
- R6: The new step is clamped to the range [`STEP_MIN`, `STEP_MAX`].
- R7: The new prediction is the old prediction plus the new step when `code[1]` is 1, or minus it when `code[1]` is 0. The result saturates to the signed `DW`-bit range.
- R8: `codeValid` is high exactly one cycle after each cycle with `sampleValid` high. Cycles without `sampleValid` leave `recon` and the adaptation state unchanged.
- R9: Every scaling by a constant computes (v*c + 2^(FRAC-1)) >> FRAC on unsigned values, which rounds to nearest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Qualifies `sample` for this cycle |
| sample | input | DW | Signed input sample |
| code | output | 2 | Codeword: bit 1 is the sign bit, bit 0 is the step-up bit |
| codeValid | output | 1 | High in the cycle after an accepted sample |
| recon | output | DW | Current prediction (reconstructed value) |

## Verification
The codeword and the updated `recon` both come from registers loaded on the edge that accepts a sample. They are therefore due one cycle after `sampleValid`, in the same cycle that `codeValid` is high. The driver pushes each expected codeword and prediction into a queue at the moment it drives the sample. The monitor samples on the falling edge and pops one entry for every cycle in which `codeValid` is high, so every comparison falls exactly one cycle after its stimulus. During idle gaps the bench checks that `codeValid` stays low and that `recon` holds its last value.

// File: rtl/adm2_pkg.sv
package adm2_pkg;
  typedef struct packed {
    logic update;
    logic clear;
  } admCtrl_t;
endpackage

// File: rtl/adm2_ctrl.sv
module adm2_ctrl
  import adm2_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sampleValid,
  output admCtrl_t ctrl,
  output logic     codeValid
);
  always_comb begin
    ctrl.clear  = rst;
    ctrl.update = sampleValid && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) codeValid <= 1'b0;
    else     codeValid <= sampleValid;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> codeValid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> !codeValid); // R8
endmodule

// File: rtl/adm2_datapath.sv
module adm2_datapath
  import adm2_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SW          = 16,
  parameter int FRAC        = 12,
  parameter int ALPHA_Q     = 4506,
  parameter int INV_ALPHA_Q = 3724,
  parameter int BETA_Q      = 7782,
  parameter int INV_BETA_Q  = 2156,
  parameter int GAMMA_Q     = 6144,
  parameter int MID_Q       = 4969,
  parameter int STEP_INIT   = 256,
  parameter int STEP_MIN    = 26,
  parameter int STEP_MAX    = 2560
) (
  input  logic                 clk,
  input  admCtrl_t             ctrl,
  input  logic signed [DW-1:0] sample,
  output logic [1:0]           code,
  output logic signed [DW-1:0] recon
);
  localparam int CW   = FRAC + 4;
  localparam int WW   = SW + 6;
  localparam int PW   = WW + CW;
  localparam int SUMW = DW + 2;
  localparam logic [PW-1:0] HALF = PW'(1) << (FRAC - 1);
  localparam logic signed [SUMW-1:0] YMAX = SUMW'((1 << (DW - 1)) - 1);
  localparam logic signed [SUMW-1:0] YMIN = -SUMW'(1 << (DW - 1));

  logic signed [DW-1:0] yReg;
  logic [SW-1:0]        stepReg;
  logic                 l1Prev, l2Prev;

  function automatic logic [WW-1:0] scaleQ(input logic [WW-1:0] v, input int c);
    logic [PW-1:0] p;
    p = PW'(v) * PW'(c) + HALF;
    return WW'(p >> FRAC);
  endfunction

  logic signed [DW:0]   errW;
  logic [DW:0]          mag;
  logic                 l1New, l2New, boost;
  logic [WW-1:0]        nStep, thr, sBeta, sGamma;
  logic [SW-1:0]        stepNext;
  logic signed [SUMW-1:0] sumW;
  logic signed [DW-1:0] yNext;

  always_comb begin
    errW  = $signed({sample[DW-1], sample}) - $signed({yReg[DW-1], yReg});
    l1New = !errW[DW];
    mag   = l1New ? $unsigned(errW) : $unsigned(-errW);
    nStep = scaleQ(WW'(stepReg), (l1New == l1Prev) ? ALPHA_Q : INV_ALPHA_Q);
    thr   = scaleQ(nStep, MID_Q);
    l2New = (WW'(mag) >= thr);
    sBeta = scaleQ(nStep, l2New ? BETA_Q : INV_BETA_Q);
    boost = !l2New && !l2Prev;
    sGamma = boost ? scaleQ(sBeta, GAMMA_Q) : sBeta;
    if (sGamma > WW'(STEP_MAX))      stepNext = SW'(STEP_MAX);
    else if (sGamma < WW'(STEP_MIN)) stepNext = SW'(STEP_MIN);
    else                             stepNext = SW'(sGamma);
    sumW = l1New ? (SUMW'(yReg) + $signed(SUMW'(stepNext)))
                 : (SUMW'(yReg) - $signed(SUMW'(stepNext)));
    if (sumW > YMAX)      yNext = DW'(YMAX);
    else if (sumW < YMIN) yNext = DW'(YMIN);
    else                  yNext = DW'(sumW);
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      yReg    <= '0;
      stepReg <= SW'(STEP_INIT);
      l1Prev  <= 1'b1;
      l2Prev  <= 1'b1;
      code    <= 2'b11;
    end else if (ctrl.update) begin
      yReg    <= yNext;
      stepReg <= stepNext;
      l1Prev  <= l1New;
      l2Prev  <= l2New;
      code    <= {l1New, l2New};
    end
  end

  assign recon = yReg;

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (ctrl.clear)
    (stepReg >= SW'(STEP_MIN)) && (stepReg <= SW'(STEP_MAX))); // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    ctrl.clear |=> (yReg == '0) && (stepReg == SW'(STEP_INIT)) && (code == 2'b11)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.update |=> $stable(yReg) && $stable(stepReg) && $stable(code)); // R8
  AST_PRED_DIRECTION: assert property (@(posedge clk) disable iff (ctrl.clear)
    ctrl.update |=> (code[1] ? (yReg >= $past(yReg)) : (yReg <= $past(yReg)))); // R7
endmodule

// File: rtl/adm2_encoder.sv
module adm2_encoder
  import adm2_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SW          = 16,
  parameter int FRAC        = 12,
  parameter int ALPHA_Q     = 4506,
  parameter int INV_ALPHA_Q = 3724,
  parameter int BETA_Q      = 7782,
  parameter int INV_BETA_Q  = 2156,
  parameter int GAMMA_Q     = 6144,
  parameter int MID_Q       = 4969,
  parameter int STEP_INIT   = 256,
  parameter int STEP_MIN    = 26,
  parameter int STEP_MAX    = 2560
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sampleValid,
  input  logic signed [DW-1:0] sample,
  output logic [1:0]           code,
  output logic                 codeValid,
  output logic signed [DW-1:0] recon
);
  admCtrl_t ctrl;

  adm2_ctrl uCtrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .ctrl(ctrl), .codeValid(codeValid)
  );

  adm2_datapath #(
    .DW(DW), .SW(SW), .FRAC(FRAC),
    .ALPHA_Q(ALPHA_Q), .INV_ALPHA_Q(INV_ALPHA_Q),
    .BETA_Q(BETA_Q), .INV_BETA_Q(INV_BETA_Q),
    .GAMMA_Q(GAMMA_Q), .MID_Q(MID_Q),
    .STEP_INIT(STEP_INIT), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
  ) uDp (
    .clk(clk), .ctrl(ctrl), .sample(sample),
    .code(code), .recon(recon)
  );
endmodule

// File: tb/adm2_encoder_test.sv
module adm2_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam longint A = 4506, IA = 3724, B = 7782, IB = 2156, G = 6144, MID = 4969;
  localparam longint SINIT = 256, SMIN = 26, SMAX = 2560;

  logic clk = 0, rst = 1, sampleValid = 0;
  logic signed [DW-1:0] sample = '0;
  logic [1:0] code;
  logic codeValid;
  logic signed [DW-1:0] recon;

  int checks = 0, failures = 0;
  logic [1:0] expCode[$];
  longint     expRecon[$];
  string      expTag[$];
  longint my, mstep;
  bit ml1p, ml2p;
  longint lastRecon = 0;
  bit done = 0;

  adm2_encoder uut (.clk(clk), .rst(rst), .sampleValid(sampleValid), .sample(sample),
                    .code(code), .codeValid(codeValid), .recon(recon));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint rnd(longint v, longint c);
    return (v * c + 2048) >>> 12;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendSample(longint x, string tag);
    longint err, mag, ns, thr, s;
    bit l1, l2;
    @(negedge clk);
    sampleValid = 1;
    sample = DW'(x);
    err = x - my;
    l1 = (err >= 0);
    mag = l1 ? err : -err;
    ns = rnd(mstep, (l1 == ml1p) ? A : IA);
    thr = rnd(ns, MID);
    l2 = (mag >= thr);
    s = rnd(ns, l2 ? B : IB);
    if (!l2 && !ml2p) s = rnd(s, G);
    if (s > SMAX) s = SMAX;
    if (s < SMIN) s = SMIN;
    my = l1 ? my + s : my - s;
    if (my > 32767) my = 32767;
    if (my < -32768) my = -32768;
    mstep = s; ml1p = l1; ml2p = l2;
    expCode.push_back({l1, l2});
    expRecon.push_back(my);
    expTag.push_back(tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    sampleValid = 0;
    repeat (n) begin
      @(negedge clk);
      check(codeValid == 0, "R8 idle codeValid", codeValid, 0);
      check(recon == lastRecon, "R8 idle recon hold", recon, lastRecon);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && codeValid) begin
      if (expCode.size() == 0) begin
        check(0, "R8 unexpected codeValid", 1, 0);
      end else begin
        logic [1:0] ec;
        longint er;
        string t;
        ec = expCode.pop_front(); er = expRecon.pop_front(); t = expTag.pop_front();
        check(code == ec, {t, " code"}, code, ec);
        check(recon == er, {t, " recon"}, recon, er);
      end
      lastRecon = recon;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    my = 0; mstep = SINIT; ml1p = 1; ml2p = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state seen at the ports
    check(codeValid == 0, "R1 codeValid", codeValid, 0);
    check(recon == 0, "R1 recon", recon, 0);
    check(code == 2'b11, "R1 code", code, 3);
    // R2 zero error gives sign bit 1
    sendSample(0, "R2 R5 zero error");
    sendSample(0, "R2 R5 zero error");
    // R4 R3 large step input, growth to upper clamp
    for (int i = 0; i < 40; i++) sendSample(20000, "R3 R4 R6 step up");
    // R7 saturation at top of range
    for (int i = 0; i < 30; i++) sendSample(32767, "R7 saturate high");
    for (int i = 0; i < 40; i++) sendSample(-32768, "R7 saturate low");
    // R5 R6 steady input, shrink toward lower clamp
    for (int i = 0; i < 60; i++) sendSample(-5000, "R5 R6 settle");
    // R9 triangle wave mixes all six ratios
    for (int i = 0; i < 200; i++) begin
      int ph = i % 50;
      sendSample((ph < 25) ? ph * 600 - 7000 : (50 - ph) * 600 - 7000, "R3 R4 R9 triangle");
    end
    idle(1);
    idle(4);
    // R8 gapped strobes
    for (int i = 0; i < 6; i++) begin
      sendSample(1000 * i, "R8 gapped");
      idle(2);
    end
    repeat (3) @(negedge clk);
    check(expCode.size() == 0, "R8 queue drained", expCode.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule